// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block holds the power-management event logic that system software reaches through a small register port. The port takes 16-bit writes and returns reads up to 32 bits wide. A free-running timer advances by one on each cycle of a tick-enable strobe. The strobe is supplied at the power-management timer rate of 3,579,545 Hz. Software reads the timer as a zero-extended 32-bit word.

Whenever the timer's top bit changes value, the block records a timer-overflow event. Three external sources enter as one-clock pulses: a real-time-clock alarm, the power button and a global-lock release. All four events are kept in a write-one-to-clear status register. An enable register selects which events drive the level-sensitive system control interrupt (SCI) output.

A control register stores the sleep type. One bit of it acts as a sleep-enable strobe and is never stored. When a write sets that strobe with sleep type 0, a small sequencer gives a one-clock power-off request. The sequencer has two states:
- **ST_RUN**: the idle state.
- **ST_OFF**: the state that drives the request.

It has two transitions:
- **GO_OFF**: from ST_RUN to ST_OFF, on a qualifying control write.
- **BACK_RUN**: from ST_OFF to ST_RUN, always after one cycle.

Top module: `pm_event_block`

## Requirements
- R1: After reset, the status, enable and control registers read 0, the timer reads 0, and `sci` and `poweroff_req` are 0.
- R2: The timer advances by exactly one on each clock edge at which `tmr_tick` is 1. It holds its value otherwise. Offset 0x08 reads it in bits TMR_W-1:0, and all upper bits read 0.
- R3: Status bit 0 becomes 1 on the edge at which the timer's top bit changes value. This applies to both the 0-to-1 and the 1-to-0 change.
- R4: A write to the status register at offset 0x00 clears each status bit written as 1. Bits written as 0 are unchanged.
- R5: A one-clock pulse sets a status bit on the next edge: `evt_rtc` sets bit 10, `evt_pwrbtn` sets bit 8 and `evt_gbl` sets bit 5. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R6: `sci` is 1 exactly when, one cycle earlier, some status bit among 0, 5, 8 and 10 was 1 together with the same bit of the enable register. Enable bits outside these four never raise `sci`.
- R7: The enable register at offset 0x02 stores all 16 written bits and reads them back.
- R8: The control register at offset 0x04 stores every written bit except bit 13. Bit 13 always reads 0, and bits 12:10 hold the sleep type.
- R9: A control write with bit 13 set and bits 12:10 equal to 0 makes `poweroff_req` 1 for exactly the one cycle after the write. Any other control write leaves it 0.
- R10: Reads of offsets other than 0x00, 0x02, 0x04 and 0x08 return 0. Writes to those other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_tick | input | 1 | Timer advance strobe |
| evt_rtc | input | 1 | Real-time-clock alarm pulse |
| evt_pwrbtn | input | 1 | Power-button pulse |
| evt_gbl | input | 1 | Global-lock release pulse |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| sci | output | 1 | Level system control interrupt |
| poweroff_req | output | 1 | One-clock soft power-off request |

## Verification
The embedded assertions watch a set of behaviours on every cycle:
- a timer overflow always reaches status bit 0;
- an event pulse always sets its bit, even against a clear;
- a write-one-to-clear clears bit 0 when no set competes;
- the timer holds without a tick;
- the stored sleep-enable bit stays 0;
- every power-off pulse lasts one cycle and follows a qualifying write.

Only the bench scenarios can show the rest: the values software reads back, the one-cycle lag of `sci` behind each status or enable change, the ignored enable bits, the non-zero sleep types and the unmapped offsets.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int OFS_STS = 'h00;
    localparam int OFS_EN  = 'h02;
    localparam int OFS_CTL = 'h04;
    localparam int OFS_TMR = 'h08;

    localparam int BIT_TMROVF = 0;
    localparam int BIT_GBL    = 5;
    localparam int BIT_PWRBTN = 8;
    localparam int BIT_RTC    = 10;
    localparam int BIT_SLPEN  = 13;
    localparam int SLPTYP_LO  = 10;
    localparam int SLPTYP_W   = 3;

    localparam logic [15:0] SCI_MASK = 16'h0521;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_OFF = 1'b1
    } slp_state_t;
endpackage

// File: rtl/pm_tmr.sv
module pm_tmr #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [TMR_W-1:0] cnt,
    output logic             ovf
);
    logic [TMR_W-1:0] nxt;

    always_comb begin
        nxt = cnt + 1'b1;
        ovf = tick & (nxt[TMR_W-1] ^ cnt[TMR_W-1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= nxt;
    end

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R2
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] set_vec,
    output logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] en,
    output logic             sci
);
    localparam logic [REG_W-1:0] MASK = REG_W'(SCI_MASK);

    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] sts_nxt;

    always_comb begin
        clr_vec = wr_sts ? wdata : '0;
        sts_nxt = (sts & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            en  <= '0;
            sci <= 1'b0;
        end else begin
            sts <= sts_nxt;
            if (wr_en)
                en <= wdata;
            sci <= |(sts & en & MASK);
        end
    end

    AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[BIT_RTC] |=> sts[BIT_RTC]); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[BIT_TMROVF] && !set_vec[BIT_TMROVF]) |=> !sts[BIT_TMROVF]); // R4
endmodule

// File: rtl/pm_slp_ctl.sv
module pm_slp_ctl
    import pm_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctl,
    output logic             poweroff
);
    slp_state_t state, state_nxt;
    logic       go_off;

    always_comb begin
        go_off = wr_ctl && wdata[BIT_SLPEN] &&
                 (wdata[SLPTYP_LO +: SLPTYP_W] == '0);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: if (go_off) state_nxt = ST_OFF; // GO_OFF
            ST_OFF: state_nxt = ST_RUN;             // BACK_RUN
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            ctl   <= '0;
        end else begin
            state <= state_nxt;
            if (wr_ctl) begin
                ctl            <= wdata;
                ctl[BIT_SLPEN] <= 1'b0;
            end
        end
    end

    always_comb begin
        poweroff = (state == ST_OFF);
    end

    AST_PWROFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        poweroff |=> !poweroff); // R9
    AST_PWROFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(poweroff) |-> $past(wr_ctl && wdata[BIT_SLPEN] &&
                                  wdata[SLPTYP_LO +: SLPTYP_W] == '0)); // R9
    AST_SLPEN_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[BIT_SLPEN]); // R8
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
    import pm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int REG_W  = 16,
    parameter int DATA_W = 32,
    parameter int TMR_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_tick,
    input  logic              evt_rtc,
    input  logic              evt_pwrbtn,
    input  logic              evt_gbl,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sci,
    output logic              poweroff_req
);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(OFS_TMR);

    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_ovf;
    logic [REG_W-1:0] sts, en, ctl, set_vec;
    logic             wr_sts, wr_en, wr_ctl;

    always_comb begin
        wr_sts = bus_wr && (bus_addr == A_STS);
        wr_en  = bus_wr && (bus_addr == A_EN);
        wr_ctl = bus_wr && (bus_addr == A_CTL);
        set_vec             = '0;
        set_vec[BIT_TMROVF] = tmr_ovf;
        set_vec[BIT_GBL]    = evt_gbl;
        set_vec[BIT_PWRBTN] = evt_pwrbtn;
        set_vec[BIT_RTC]    = evt_rtc;
    end

    pm_tmr #(.TMR_W(TMR_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tmr_tick),
        .cnt  (tmr_cnt),
        .ovf  (tmr_ovf)
    );

    pm_evt_regs #(.REG_W(REG_W)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sts (wr_sts),
        .wr_en  (wr_en),
        .wdata  (bus_wdata),
        .set_vec(set_vec),
        .sts    (sts),
        .en     (en),
        .sci    (sci)
    );

    pm_slp_ctl #(.REG_W(REG_W)) u_slp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (wr_ctl),
        .wdata   (bus_wdata),
        .ctl     (ctl),
        .poweroff(poweroff_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STS)
            bus_rdata = DATA_W'(sts);
        else if (bus_addr == A_EN)
            bus_rdata = DATA_W'(en);
        else if (bus_addr == A_CTL)
            bus_rdata = DATA_W'(ctl);
        else if (bus_addr == A_TMR)
            bus_rdata = DATA_W'(tmr_cnt);
    end

    AST_OVF_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> sts[BIT_TMROVF]); // R3
endmodule

// File: tb/test_pm_event_block.sv
module test_pm_event_block;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_tick = 1'b0;
    logic        evt_rtc = 1'b0, evt_pwrbtn = 1'b0, evt_gbl = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sci, poweroff_req;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_event_block #(.TMR_W(TW)) i_pm_event_block (
        .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick),
        .evt_rtc(evt_rtc), .evt_pwrbtn(evt_pwrbtn), .evt_gbl(evt_gbl),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sci(sci), .poweroff_req(poweroff_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        tmr_tick = 1'b1;
        repeat (n) @(negedge clk);
        tmr_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(6'h00, d); chk("R1 status", d, 0);
        rd(6'h02, d); chk("R1 enable", d, 0);
        rd(6'h04, d); chk("R1 control", d, 0);
        rd(6'h08, d); chk("R1 timer", d, 0);
        chk("R1 sci", {31'b0, sci}, 0);
        chk("R1 poweroff", {31'b0, poweroff_req}, 0);
    endtask

    task automatic t_timer();
        logic [31:0] d;
        do_reset();
        ticks(5);
        rd(6'h08, d); chk("R2 timer after 5 ticks", d, 5);
        repeat (3) @(negedge clk);
        rd(6'h08, d); chk("R2 timer holds", d, 5);
        ticks(300);
        rd(6'h08, d); chk("R2 timer 305 upper bits zero", d, 305);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        do_reset();
        ticks((1 << (TW-1)) - 1);
        rd(6'h00, d); chk("R3 no overflow before msb change", d, 0);
        ticks(1);
        rd(6'h00, d); chk("R3 overflow on msb rise", d, 1);
        wr(6'h00, 16'h0001);
        rd(6'h00, d); chk("R4 overflow cleared", d, 0);
        ticks((1 << (TW-1)) - 1);
        rd(6'h00, d); chk("R3 no overflow before wrap", d, 0);
        ticks(1);
        rd(6'h00, d); chk("R3 overflow on msb fall", d, 1);
        rd(6'h08, d); chk("R2 timer wrapped", d, 0);
    endtask

    task automatic t_events();
        logic [31:0] d;
        do_reset();
        evt_rtc = 1'b1; evt_pwrbtn = 1'b1; evt_gbl = 1'b1;
        @(negedge clk);
        evt_rtc = 1'b0; evt_pwrbtn = 1'b0; evt_gbl = 1'b0;
        rd(6'h00, d); chk("R5 three events set", d, 32'h0520);
        wr(6'h00, 16'h0020);
        rd(6'h00, d); chk("R4 clear only bit 5", d, 32'h0500);
        wr(6'h00, 16'h0000);
        rd(6'h00, d); chk("R4 zero write keeps bits", d, 32'h0500);
        evt_pwrbtn = 1'b1;
        wr(6'h00, 16'h0100);
        evt_pwrbtn = 1'b0;
        rd(6'h00, d); chk("R5 set beats clear", d, 32'h0500);
    endtask

    task automatic t_sci();
        do_reset();
        wr(6'h02, 16'hFADE);
        evt_gbl = 1'b1; @(negedge clk); evt_gbl = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 unmatched enable no sci", {31'b0, sci}, 0);
        wr(6'h02, 16'h0400);
        evt_rtc = 1'b1; @(negedge clk); evt_rtc = 1'b0;
        chk("R6 sci lags status", {31'b0, sci}, 0);
        @(negedge clk);
        chk("R6 sci raised by rtc", {31'b0, sci}, 1);
        wr(6'h00, 16'h0400);
        chk("R6 sci lags clear", {31'b0, sci}, 1);
        @(negedge clk);
        chk("R6 sci dropped", {31'b0, sci}, 0);
        wr(6'h02, 16'h0020);
        chk("R6 enable lag", {31'b0, sci}, 0);
        @(negedge clk);
        chk("R6 sci from pending global", {31'b0, sci}, 1);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        do_reset();
        wr(6'h02, 16'hA5C3);
        rd(6'h02, d); chk("R7 enable readback", d, 32'hA5C3);
        wr(6'h02, 16'h5A3C);
        rd(6'h02, d); chk("R7 enable readback 2", d, 32'h5A3C);
    endtask

    task automatic t_control();
        logic [31:0] d;
        do_reset();
        wr(6'h04, 16'h2C55);
        rd(6'h04, d); chk("R8 control bit13 dropped", d, 32'h0C55);
        chk("R9 type 3 no poweroff", {31'b0, poweroff_req}, 0);
        @(negedge clk);
        chk("R9 type 3 no poweroff later", {31'b0, poweroff_req}, 0);
        wr(6'h04, 16'h0055);
        chk("R9 no strobe no poweroff", {31'b0, poweroff_req}, 0);
        rd(6'h04, d); chk("R8 control plain", d, 32'h0055);
        wr(6'h04, 16'h2055);
        chk("R9 soft off pulse", {31'b0, poweroff_req}, 1);
        rd(6'h04, d); chk("R8 control after soft off", d, 32'h0055);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'b0, poweroff_req}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        do_reset();
        wr(6'h02, 16'h1234);
        wr(6'h04, 16'h0101);
        wr(6'h06, 16'hFFFF);
        wr(6'h0A, 16'hFFFF);
        rd(6'h02, d); chk("R10 enable untouched", d, 32'h1234);
        rd(6'h04, d); chk("R10 control untouched", d, 32'h0101);
        rd(6'h00, d); chk("R10 status untouched", d, 0);
        rd(6'h06, d); chk("R10 read 0x06", d, 0);
        rd(6'h0A, d); chk("R10 read 0x0A", d, 0);
        rd(6'h3E, d); chk("R10 read 0x3E", d, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_timer();
        t_overflow();
        t_events();
        t_sci();
        t_enable();
        t_control();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule